// File: doc/BRIEF.md
# Transmit Frame Check Sequence Appender with Abort

This block sits in an Ethernet transmit byte path. It passes payload bytes from an upstream source to a downstream consumer and, once the source marks the final payload byte, appends the four bytes of the CRC-32 frame check sequence. It computes the CRC byte by byte as the payload flows through, so the stream sees no added latency.

A separate abort input lets the surrounding logic end a frame early, for example after a fatal bus error. The block then stops forwarding payload at the next byte boundary and sends the running CRC register without its final complement, which is the bitwise inverse of the correct check value. A receiver therefore sees either a runt or a frame with a bad check sequence. The rest of the aborted frame's input bytes are consumed and discarded until the source's last flag appears. Both sides use a valid/ready handshake, and a byte moves when valid and ready are both high at a rising clock edge.

Top module: `fcs_tx_appender`

## Requirements
- R1: With no frame check bytes pending, each input byte goes to the output unchanged, with out_last low. in_ready equals out_ready, and out_valid equals in_valid.
- R2: After the byte marked in_last is accepted, the block sends four check bytes. They are the complement of the CRC-32 register, least significant byte first. The CRC uses the reflected polynomial 0xEDB88320 (0x04C11DB7 in normal form), reflected input and output, and an initial value of 0xFFFFFFFF. For the ASCII payload "123456789" the four bytes are 0x26, 0x39, 0xF4, 0xCB.
- R3: out_last is high only on the fourth check byte of a frame, whether the frame ended normally or by abort.
- R4: The CRC register returns to 0xFFFFFFFF at the end of every frame, so each frame's check value depends only on its own payload.
- R5: An abort_req seen while a frame is in progress forwards no further payload; the input byte offered in that cycle is also withheld. A frame is in progress once at least one of its bytes has been accepted. The next four output bytes are the uncomplemented CRC register, least significant byte first, which is the bitwise inverse of the correct check value.
- R6: After an aborted frame's check bytes, the block accepts and discards input bytes up to and including the one marked in_last. It sends nothing on the output while it does so.
- R7: An abort_req that arrives while normal check bytes are being sent is ignored, and the frame ends with its correct check value.
- R8: An abort_req that arrives while no frame is in progress is ignored.
- R9: While check bytes are being sent, in_ready is low. When out_ready is low, the same check byte stays on the output until it is accepted.
- R10: While reset is asserted and just after it, out_valid and out_last are low with no input valid, and in_ready follows out_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Upstream byte valid |
| in_data | input | 8 | Upstream payload byte |
| in_last | input | 1 | Marks the final payload byte of a frame |
| in_ready | output | 1 | Block accepts the upstream byte |
| abort_req | input | 1 | Ends the frame in progress with a corrupted check value |
| out_valid | output | 1 | Downstream byte valid |
| out_data | output | 8 | Downstream byte (payload or check byte) |
| out_last | output | 1 | Marks the final check byte of a frame |
| out_ready | input | 1 | Downstream accepts the byte |

## Verification
The assertions assume that every frame the source starts ends with a byte marked in_last. They also assume that abort_req, in_valid and out_ready are never unknown after reset. The stimulus keeps to this: it offers each byte until that byte is accepted, always completes aborted frames through their last byte, and pulses abort_req for one cycle at chosen points. Those points are before any byte, in mid-frame, and just after the last byte. Downstream readiness follows several fixed and pseudo-random patterns, so the check-byte hold and the pass-through path are both exercised under backpressure.

// File: rtl/fcs_tx_pkg.sv
package fcs_tx_pkg;

  typedef enum logic [1:0] {
    ST_PASS  = 2'd0,
    ST_FCS   = 2'd1,
    ST_ABORT = 2'd2,
    ST_DRAIN = 2'd3
  } fcs_st_e;

endpackage

// File: rtl/fcs_tx_crc.sv
module fcs_tx_crc #(
  parameter int          CRC_W    = 32,
  parameter int          BYTE_W   = 8,
  parameter logic [31:0] POLY_REV = 32'hEDB88320,
  parameter logic [31:0] SEED     = 32'hFFFFFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_en,
  input  logic              upd_en,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [CRC_W-1:0]  crc_q
);

  localparam logic [CRC_W-1:0] POLY_L = POLY_REV[CRC_W-1:0];
  localparam logic [CRC_W-1:0] SEED_L = SEED[CRC_W-1:0];

  logic [CRC_W-1:0] crc_d;

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c_in,
                                                input logic [BYTE_W-1:0] b);
    logic [CRC_W-1:0] c;
    c = c_in;
    for (int k = 0; k < BYTE_W; k++) begin
      if (c[0] ^ b[k]) c = (c >> 1) ^ POLY_L;
      else             c = c >> 1;
    end
    return c;
  endfunction

  always_comb begin
    crc_d = crc_q;
    if (clr_en)      crc_d = SEED_L;
    else if (upd_en) crc_d = crc_step(crc_q, byte_in);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= SEED_L;
    else        crc_q <= crc_d;
  end

endmodule

// File: rtl/fcs_tx_ctrl.sv
module fcs_tx_ctrl
  import fcs_tx_pkg::*;
#(
  parameter int FCS_BYTES = 4,
  parameter int IDX_W     = (FCS_BYTES > 1) ? $clog2(FCS_BYTES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_last,
  input  logic             abort_req,
  input  logic             out_ready,
  output logic             in_ready,
  output logic             out_valid,
  output logic             out_last,
  output logic             crc_upd,
  output logic             crc_clr,
  output fcs_st_e          st_q,
  output logic [IDX_W-1:0] idx_q,
  output logic             act_q
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FCS_BYTES - 1);

  fcs_st_e          st_d;
  logic [IDX_W-1:0] idx_d;
  logic             act_d;

  always_comb begin
    st_d      = st_q;
    idx_d     = idx_q;
    act_d     = act_q;
    in_ready  = 1'b0;
    out_valid = 1'b0;
    out_last  = 1'b0;
    crc_upd   = 1'b0;
    crc_clr   = 1'b0;
    unique case (st_q)
      ST_PASS: begin
        if (abort_req && act_q) begin
          st_d  = ST_ABORT;
          idx_d = '0;
        end else begin
          in_ready  = out_ready;
          out_valid = in_valid;
          if (in_valid && out_ready) begin
            crc_upd = 1'b1;
            act_d   = 1'b1;
            if (in_last) begin
              st_d  = ST_FCS;
              idx_d = '0;
            end
          end
        end
      end
      ST_FCS, ST_ABORT: begin
        out_valid = 1'b1;
        out_last  = (idx_q == LAST_IDX);
        if (out_ready) begin
          if (idx_q == LAST_IDX) begin
            crc_clr = 1'b1;
            act_d   = 1'b0;
            idx_d   = '0;
            st_d    = (st_q == ST_FCS) ? ST_PASS : ST_DRAIN;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      ST_DRAIN: begin
        in_ready = 1'b1;
        if (in_valid && in_last) st_d = ST_PASS;
      end
      default: st_d = ST_PASS;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_PASS;
      idx_q <= '0;
      act_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      act_q <= act_d;
    end
  end

endmodule

// File: rtl/fcs_tx_outmux.sv
module fcs_tx_outmux
  import fcs_tx_pkg::*;
#(
  parameter int CRC_W     = 32,
  parameter int BYTE_W    = 8,
  parameter int FCS_BYTES = CRC_W / BYTE_W,
  parameter int IDX_W     = (FCS_BYTES > 1) ? $clog2(FCS_BYTES) : 1
) (
  input  fcs_st_e           st,
  input  logic [IDX_W-1:0]  idx,
  input  logic [CRC_W-1:0]  crc,
  input  logic [BYTE_W-1:0] in_data,
  output logic [BYTE_W-1:0] out_data
);

  logic [CRC_W-1:0]  word;
  logic [BYTE_W-1:0] lane [FCS_BYTES];

  // normal end sends the complement, abort sends the raw register
  assign word = (st == ST_FCS) ? ~crc : crc;

  for (genvar g = 0; g < FCS_BYTES; g++) begin : g_lane
    assign lane[g] = word[g*BYTE_W +: BYTE_W];
  end

  always_comb begin
    if (st == ST_PASS) out_data = in_data;
    else               out_data = lane[idx];
  end

endmodule

// File: rtl/fcs_tx_appender.sv
module fcs_tx_appender
  import fcs_tx_pkg::*;
#(
  parameter int          CRC_W    = 32,
  parameter int          BYTE_W   = 8,
  parameter logic [31:0] POLY_REV = 32'hEDB88320,
  parameter logic [31:0] SEED     = 32'hFFFFFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_last,
  output logic              in_ready,
  input  logic              abort_req,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_last,
  input  logic              out_ready
);

  localparam int FCS_BYTES = CRC_W / BYTE_W;
  localparam int IDX_W     = (FCS_BYTES > 1) ? $clog2(FCS_BYTES) : 1;

  fcs_st_e          st_w;
  logic [IDX_W-1:0] idx_w;
  logic             act_w;
  logic             upd_w;
  logic             clr_w;
  logic [CRC_W-1:0] crc_w;

  fcs_tx_ctrl #(
    .FCS_BYTES (FCS_BYTES),
    .IDX_W     (IDX_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .abort_req (abort_req),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_last  (out_last),
    .crc_upd   (upd_w),
    .crc_clr   (clr_w),
    .st_q      (st_w),
    .idx_q     (idx_w),
    .act_q     (act_w)
  );

  fcs_tx_crc #(
    .CRC_W    (CRC_W),
    .BYTE_W   (BYTE_W),
    .POLY_REV (POLY_REV),
    .SEED     (SEED)
  ) u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_en  (clr_w),
    .upd_en  (upd_w),
    .byte_in (in_data),
    .crc_q   (crc_w)
  );

  fcs_tx_outmux #(
    .CRC_W     (CRC_W),
    .BYTE_W    (BYTE_W),
    .FCS_BYTES (FCS_BYTES),
    .IDX_W     (IDX_W)
  ) u_mux (
    .st       (st_w),
    .idx      (idx_w),
    .crc      (crc_w),
    .in_data  (in_data),
    .out_data (out_data)
  );

endmodule

// File: rtl/fcs_tx_checker.sv
module fcs_tx_checker
  import fcs_tx_pkg::*;
#(
  parameter int CRC_W = 32,
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input fcs_st_e          st,
  input logic [IDX_W-1:0] idx,
  input logic             act,
  input logic [CRC_W-1:0] crc,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_last,
  input logic             out_ready,
  input logic             abort_req
);

  localparam logic [IDX_W-1:0] LAST_IDX = '1;

  p_last_on_final_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> (out_valid && idx == LAST_IDX && (st == ST_FCS || st == ST_ABORT)));

  p_crc_fresh_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PASS && !act) |-> (crc == '1));

  p_drain_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DRAIN) |-> (!out_valid && in_ready));

  p_abort_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FCS && abort_req) |=> (st != ST_ABORT));

  p_idle_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PASS && !act && abort_req) |=> (st != ST_ABORT));

  p_no_intake_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FCS || st == ST_ABORT) |-> !in_ready);

  p_fcs_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_FCS || st == ST_ABORT) && !out_ready) |=> ($stable(idx) && $stable(st)));

endmodule

bind fcs_tx_appender fcs_tx_checker #(
  .CRC_W (CRC_W),
  .IDX_W (IDX_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .st        (st_w),
  .idx       (idx_w),
  .act       (act_w),
  .crc       (crc_w),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_last  (out_last),
  .out_ready (out_ready),
  .abort_req (abort_req)
);

// File: tb/fcs_tx_appender_tb.sv
`timescale 1ns/1ps
module fcs_tx_appender_tb;

  logic       clk;
  logic       rst_n;
  logic       in_valid;
  logic [7:0] in_data;
  logic       in_last;
  logic       in_ready;
  logic       abort_req;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_last;
  logic       out_ready;

  int errors;
  int checks;
  int cyc;
  int rdy_mode;
  logic [7:0] lfsr;

  logic [7:0] exp_d [0:63];
  logic       exp_l [0:63];
  int         exp_n;
  logic [7:0] got_d [0:63];
  logic       got_l [0:63];
  int         got_n;
  logic [7:0] pay [0:63];

  fcs_tx_appender u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_last   (in_last),
    .in_ready  (in_ready),
    .abort_req (abort_req),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last),
    .out_ready (out_ready)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // downstream readiness patterns, changed shortly after each rising edge
  always @(posedge clk) begin
    cyc  <= cyc + 1;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    #2;
    case (rdy_mode)
      0: out_ready = 1'b1;
      1: out_ready = cyc[0];
      2: out_ready = (cyc % 3) != 0;
      default: out_ready = lfsr[0] | lfsr[2];
    endcase
  end

  // output collector: a transfer happens at the next rising edge
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready && got_n < 64) begin
      got_d[got_n] = out_data;
      got_l[got_n] = out_last;
      got_n = got_n + 1;
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below 150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] c;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      for (int b = 0; b < 8; b++) begin
        logic fb;
        fb = c[0] ^ pay[i][b];
        c  = {1'b0, c[31:1]};
        if (fb) c = c ^ 32'hEDB88320;
      end
    end
    return c;
  endfunction

  task automatic push_byte(input logic [7:0] d, input logic l);
    logic done;
    in_valid = 1'b1;
    in_data  = d;
    in_last  = l;
    done     = 1'b0;
    while (!done) begin
      @(negedge clk);
      done = in_ready;
      @(posedge clk);
      #2;
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic pulse_abort();
    abort_req = 1'b1;
    @(posedge clk);
    #2;
    abort_req = 1'b0;
  endtask

  // abort_pos: index of the byte before which an abort is pulsed (-1 none)
  task automatic run_frame(input int len, input int seed, input int abort_pos,
                           input bit abort_tail, input string tag);
    logic [31:0] c;
    int k;
    bit aborted;
    int w;
    bit bad;
    for (int i = 0; i < len; i++) pay[i] = 8'((seed * 7 + i * 13 + (i * i)) & 255);
    aborted = (abort_pos >= 1 && abort_pos < len);
    k       = aborted ? abort_pos : len;
    c       = ref_crc(k);
    if (!aborted) c = ~c;
    exp_n = 0;
    for (int i = 0; i < k; i++) begin
      exp_d[exp_n] = pay[i]; exp_l[exp_n] = 1'b0; exp_n++;
    end
    for (int b = 0; b < 4; b++) begin
      exp_d[exp_n] = c[b*8 +: 8]; exp_l[exp_n] = (b == 3); exp_n++;
    end
    got_n = 0;
    for (int i = 0; i < len; i++) begin
      if (i == abort_pos) pulse_abort();
      push_byte(pay[i], i == len - 1);
    end
    if (abort_tail) pulse_abort();
    w = 0;
    while (got_n < exp_n && w < 200) begin
      @(posedge clk); w++;
    end
    repeat (6) @(posedge clk);
    #2;
    checks = checks + 1;
    bad = (got_n != exp_n);
    if (bad)
      $display("FAIL %s len=%0d abort=%0d mode=%0d: byte count actual=%0d expected=%0d",
               tag, len, abort_pos, rdy_mode, got_n, exp_n);
    else begin
      for (int i = 0; i < exp_n; i++) begin
        if (!bad && (got_d[i] !== exp_d[i] || got_l[i] !== exp_l[i])) begin
          bad = 1'b1;
          $display("FAIL %s len=%0d abort=%0d mode=%0d byte %0d: actual=%02h/%0b expected=%02h/%0b",
                   tag, len, abort_pos, rdy_mode, i, got_d[i], got_l[i], exp_d[i], exp_l[i]);
        end
      end
    end
    if (bad) errors = errors + 1;
  endtask

  task automatic check_bit(input logic act, input logic expv, input string what);
    checks = checks + 1;
    if (act !== expv) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0b expected=%0b", what, act, expv);
    end
  endtask

  initial begin
    errors = 0; checks = 0; cyc = 0; rdy_mode = 0; lfsr = 8'h5A;
    got_n = 0; exp_n = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_last = 1'b0;
    abort_req = 1'b0; out_ready = 1'b1;
    repeat (3) @(posedge clk);
    #3;
    // R10: reset state
    check_bit(out_valid, 1'b0, "R10 out_valid in reset");
    check_bit(out_last, 1'b0, "R10 out_last in reset");
    check_bit(in_ready, out_ready, "R10 in_ready follows out_ready in reset");
    rst_n = 1'b1;
    @(posedge clk); #2;
    check_bit(out_valid, 1'b0, "R10 out_valid after reset");
    // R1 pass-through before any handshake
    in_valid = 1'b1; in_data = 8'hA5; #1;
    checks = checks + 1;
    if (out_data !== 8'hA5 || out_valid !== 1'b1 || out_last !== 1'b0) begin
      errors = errors + 1;
      $display("FAIL R1 pass-through: actual=%02h/%0b expected=a5/1", out_data, out_valid);
    end
    in_valid = 1'b0;

    // R2 known answer: "123456789" -> 26 39 f4 cb
    got_n = 0;
    for (int i = 0; i < 9; i++) push_byte(8'h31 + 8'(i), i == 8);
    repeat (8) @(posedge clk);
    #2;
    checks = checks + 1;
    if (got_n != 13 || got_d[9] !== 8'h26 || got_d[10] !== 8'h39 ||
        got_d[11] !== 8'hF4 || got_d[12] !== 8'hCB || got_l[12] !== 1'b1) begin
      errors = errors + 1;
      $display("FAIL R2 known answer: actual n=%0d %02h%02h%02h%02h expected n=13 2639f4cb",
               got_n, got_d[9], got_d[10], got_d[11], got_d[12]);
    end

    // sweeps over readiness patterns and frame lengths
    for (int m = 0; m < 4; m++) begin
      rdy_mode = m;
      for (int len = 1; len <= 12; len++) begin
        run_frame(len, len + m * 16, -1, 1'b0, "R1 R2 R3 R4 R9 normal");
        run_frame(len, len * 3 + m, 0, 1'b0, "R8 idle abort");
        if (len >= 2) run_frame(len, len * 5 + m, len / 2, 1'b0, "R5 R6 R3 abort");
        if (len >= 3) run_frame(len, len + 99, 1, 1'b0, "R5 R6 early abort");
        run_frame(len, len * 11 + m, -1, 1'b1, "R7 abort during fcs");
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule